// File: doc/BRIEF.md
# Line AIS Detector and Inserter

This block watches the recovered receive bit stream of an E2/E3 line for the all-ones Alarm Indication Signal (AIS). It counts the zeros in each window of one frame length. A window that holds fewer than a threshold number of zeros counts as an all-ones window. A run of such windows declares the alarm, and a run of windows that hold enough zeros clears it. Because the count tolerates a couple of zeros per window, a line at a 1e-3 bit error rate is still recognised as AIS. A properly framed signal always carries five zeros in its framing word, so it is never mistaken for AIS, whatever its payload.

The unlatched alarm drives an active-low output. A sticky copy of the alarm is also kept, and a clear strobe releases it only once the alarm has gone away. While either the alarm or the aligner's loss-of-frame flag is active, the block forces ones onto the terminal-side receive data. A low level on the disable input stops this forcing. The aligner's frame-start strobe re-phases the counting window so that a whole framing word falls inside one window.

At the default E3 window of 1536 bits (about 44.7 us at 34.368 Mb/s), two windows plus two clock cycles is well under 1 ms.

Top module: `line_ais_monitor`

## Requirements
- R1: After reset `ais_no` is 1 and `ais_latched_o` is 0, and `term_data_o` equals `data_i`.
- R2: A window is `WIN_LEN` (default 1536) consecutive bits on which `valid_i` was high. Cycles with `valid_i` low are not counted. A window with fewer than `ZERO_THRESH` (default 3) zeros is an all-ones window; a window with 3 or more zeros is a zero window.
- R3: `ais_no` goes low after `DECLARE_WIN` (default 2) consecutive all-ones windows, within 2 cycles of the last bit of the second window. A single all-ones window, or one broken by a zero window, does not declare the alarm.
- R4: Once declared, `ais_no` returns high after `CLEAR_WIN` (default 2) consecutive zero windows, and not after one.
- R5: A signal whose frames each carry five zeros in the framing word, with all-ones payload, never drives `ais_no` low.
- R6: When `frame_start_i` is high together with `valid_i`, that bit becomes bit 0 of a new window. The partial window before it is discarded without being evaluated.
- R7: `ais_latched_o` goes to 1 one cycle after the alarm becomes active, and it stays 1 after the alarm clears.
- R8: A high on `latch_clr_i` while the alarm is active has no effect. A high while the alarm is inactive clears `ais_latched_o` on the next cycle.
- R9: While `ins_dis_ni` is 1 and either the alarm or `lof_i` is active, `term_data_o` is 1.
- R10: While `ins_dis_ni` is 0, `term_data_o` equals `data_i`, even during an alarm or loss of frame. `lof_i` alone never drives `ais_no` low.
- R11: `term_valid_o` equals `valid_i` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Recovered line clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 1 | Received line bit |
| valid_i | input | 1 | data_i carries a bit this cycle |
| frame_start_i | input | 1 | First bit of a frame, from the aligner |
| lof_i | input | 1 | Loss of frame from the aligner |
| ins_dis_ni | input | 1 | Low disables forcing of all ones |
| latch_clr_i | input | 1 | Clear strobe for the sticky alarm |
| ais_no | output | 1 | Unlatched alarm, active low |
| ais_latched_o | output | 1 | Sticky alarm copy |
| term_data_o | output | 1 | Terminal-side receive data |
| term_valid_o | output | 1 | Terminal-side data valid |

## Verification
The assertions assume that `frame_start_i` only matters together with `valid_i`. They also assume that the clear strobe, the disable level and `lof_i` change only between clock edges, so each one is a clean level at the edge. The bench drives every input at the falling edge and sends whole windows from a known phase. It starts from reset and re-phases only through a frame-start strobe that coincides with a valid bit. Its gaps in `valid_i` hold the data at zero, so any gap bit that is wrongly counted would show up as an extra zero.

// File: rtl/ais_pkg.sv
package ais_pkg;
  typedef struct packed {
    logic done;  // one-cycle pulse after the last bit of a window
    logic ones;  // window held fewer zeros than the threshold
  } win_res_t;
endpackage

// File: rtl/ais_window_counter.sv
module ais_window_counter
  import ais_pkg::*;
#(
  parameter int WIN_LEN     = 1536,
  parameter int ZERO_THRESH = 3
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     data_i,
  input  logic     valid_i,
  input  logic     frame_start_i,
  output win_res_t win_o
);
  localparam int CW = $clog2(WIN_LEN);
  localparam int ZW = $clog2(ZERO_THRESH + 1);
  localparam logic [ZW:0]   THR_W  = (ZW+1)'(ZERO_THRESH);
  localparam logic [CW-1:0] LAST_W = CW'(WIN_LEN - 1);

  logic [CW-1:0] bit_cnt, base_bits;
  logic [ZW-1:0] zero_cnt, base_z, zero_sat;
  logic [ZW:0]   zero_sum;
  logic          last_bit;

  // a frame-start bit always opens a fresh window
  always_comb begin
    base_bits = frame_start_i ? '0 : bit_cnt;
    base_z    = frame_start_i ? '0 : zero_cnt;
    zero_sum  = {1'b0, base_z} + (ZW+1)'(!data_i);
    zero_sat  = (zero_sum > THR_W) ? THR_W[ZW-1:0] : zero_sum[ZW-1:0];
    last_bit  = (base_bits == LAST_W);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt  <= '0;
      zero_cnt <= '0;
      win_o    <= '0;
    end else begin
      win_o.done <= 1'b0;
      if (valid_i) begin
        if (last_bit) begin
          bit_cnt    <= '0;
          zero_cnt   <= '0;
          win_o.done <= 1'b1;
          win_o.ones <= (zero_sum < THR_W);
        end else begin
          bit_cnt  <= base_bits + CW'(1);
          zero_cnt <= zero_sat;
        end
      end
    end
  end

  AST_BITCNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt <= LAST_W) else $error("bit count out of range"); // R2
  AST_DONE_NEEDS_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_o.done |-> $past(valid_i)) else $error("window closed without a bit"); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(bit_cnt)) else $error("idle cycle counted"); // R2
  AST_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && frame_start_i && WIN_LEN > 1) |=> (bit_cnt == CW'(1))) else $error("no re-phase"); // R6
endmodule

// File: rtl/ais_hysteresis.sv
module ais_hysteresis
  import ais_pkg::*;
#(
  parameter int DECLARE_WIN = 2,
  parameter int CLEAR_WIN   = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  win_res_t win_i,
  output logic     ais_o
);
  localparam int RMAX = (DECLARE_WIN > CLEAR_WIN) ? DECLARE_WIN : CLEAR_WIN;
  localparam int RW   = $clog2(RMAX + 1);
  localparam logic [RW-1:0] DEC_W = RW'(DECLARE_WIN);
  localparam logic [RW-1:0] CLR_W = RW'(CLEAR_WIN);

  logic [RW-1:0] ones_run, zero_run;
  logic          ais_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_run <= '0;
      zero_run <= '0;
      ais_q    <= 1'b0;
    end else if (win_i.done) begin
      if (win_i.ones) begin
        zero_run <= '0;
        if (ones_run != DEC_W) ones_run <= ones_run + RW'(1);
        if (ones_run >= DEC_W - RW'(1)) ais_q <= 1'b1;
      end else begin
        ones_run <= '0;
        if (zero_run != CLR_W) zero_run <= zero_run + RW'(1);
        if (zero_run >= CLR_W - RW'(1)) ais_q <= 1'b0;
      end
    end
  end

  assign ais_o = ais_q;

  AST_CHANGE_ON_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ais_q) |-> $past(win_i.done)) else $error("alarm moved off a window"); // R3
  AST_RISE_ON_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ais_q) |-> $past(win_i.ones)) else $error("declared on zero window"); // R3
  AST_FALL_ON_ZEROS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ais_q) |-> !$past(win_i.ones)) else $error("cleared on ones window"); // R4
endmodule

// File: rtl/ais_latch.sv
module ais_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic latched_o
);
  logic latched_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     latched_q <= 1'b0;
    else if (set_i)  latched_q <= 1'b1;
    else if (clr_i)  latched_q <= 1'b0;
  end

  assign latched_o = latched_q;

  AST_LATCH_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> latched_q) else $error("sticky bit missed alarm"); // R7
  AST_LATCH_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(latched_q) |-> $past(clr_i && !set_i)) else $error("sticky bit lost"); // R8
endmodule

// File: rtl/line_ais_monitor.sv
module line_ais_monitor
  import ais_pkg::*;
#(
  parameter int WIN_LEN     = 1536,
  parameter int ZERO_THRESH = 3,
  parameter int DECLARE_WIN = 2,
  parameter int CLEAR_WIN   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  input  logic valid_i,
  input  logic frame_start_i,
  input  logic lof_i,
  input  logic ins_dis_ni,
  input  logic latch_clr_i,
  output logic ais_no,
  output logic ais_latched_o,
  output logic term_data_o,
  output logic term_valid_o
);
  win_res_t win;
  logic     ais;
  logic     force_ones;

  ais_window_counter #(.WIN_LEN(WIN_LEN), .ZERO_THRESH(ZERO_THRESH)) u_win (
    .clk_i, .rst_ni, .data_i, .valid_i, .frame_start_i, .win_o(win)
  );

  ais_hysteresis #(.DECLARE_WIN(DECLARE_WIN), .CLEAR_WIN(CLEAR_WIN)) u_hyst (
    .clk_i, .rst_ni, .win_i(win), .ais_o(ais)
  );

  ais_latch u_latch (
    .clk_i, .rst_ni, .set_i(ais), .clr_i(latch_clr_i), .latched_o(ais_latched_o)
  );

  assign force_ones   = ins_dis_ni && (ais || lof_i);
  assign term_data_o  = force_ones ? 1'b1 : data_i;
  assign term_valid_o = valid_i;
  assign ais_no       = !ais;

  AST_LOF_FORCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_dis_ni && lof_i) |-> term_data_o) else $error("lof not forced"); // R9
  AST_DISABLE_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ins_dis_ni |-> (term_data_o == data_i)) else $error("forced while disabled"); // R10
  AST_LATCH_COVERS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ais_no && $past(!ais_no)) |-> ais_latched_o) else $error("sticky below alarm"); // R7
endmodule

// File: tb/line_ais_monitor_tb.sv
module line_ais_monitor_tb;
  localparam int WIN = 1536;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic data = 1'b1, valid = 1'b0, fs = 1'b0, lof = 1'b0, dis_n = 1'b1, clr = 1'b0;
  logic ais_n, latched, tdata, tvalid;
  int   errors = 0;
  int   checks = 0;

  always #5 clk = ~clk;

  line_ais_monitor u_dut (
    .clk_i(clk), .rst_ni(rst_n), .data_i(data), .valid_i(valid),
    .frame_start_i(fs), .lof_i(lof), .ins_dis_ni(dis_n), .latch_clr_i(clr),
    .ais_no(ais_n), .ais_latched_o(latched), .term_data_o(tdata), .term_valid_o(tvalid)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid = 1'b0; data = 1'b1; fs = 1'b0; clr = 1'b0;
    end
  endtask

  // nz zeros spaced 97 bits apart; optional frame start on bit 0; optional
  // valid gap with data held at zero
  task automatic send_bits(input int len, input int nz, input bit fs_first, input bit gap);
    for (int i = 0; i < len; i++) begin
      if (gap && i == 100) begin
        for (int g = 0; g < 6; g++) begin
          @(negedge clk);
          valid = 1'b0; data = 1'b0; fs = 1'b0;
        end
      end
      @(negedge clk);
      valid = 1'b1;
      fs    = fs_first && (i == 0);
      data  = !((i % 97 == 0) && (i / 97 < nz));
    end
  endtask

  task automatic send_window(input int nz, input bit fs_first, input bit gap);
    send_bits(WIN, nz, fs_first, gap);
    idle(3);
  endtask

  task automatic t_reset;
    @(negedge clk);
    data = 1'b0; valid = 1'b0;
    #1;
    chk("R1 ais_no", ais_n, 1'b1);
    chk("R1 latched", ais_latched_o_val(), 1'b0);
    chk("R1 passthrough", tdata, 1'b0);
    data = 1'b1;
  endtask

  function automatic logic ais_latched_o_val();
    return latched;
  endfunction

  task automatic t_declare;
    send_window(2, 1'b0, 1'b1);
    chk("R3 single ones window", ais_n, 1'b1);
    send_window(3, 1'b0, 1'b0);
    chk("R2 three zeros break run", ais_n, 1'b1);
    send_window(2, 1'b0, 1'b1);
    chk("R2 run restarted", ais_n, 1'b1);
    send_window(0, 1'b0, 1'b0);
    chk("R3 declared", ais_n, 1'b0);
    chk("R7 latched set", latched, 1'b1);
  endtask

  task automatic t_insert;
    @(negedge clk);
    valid = 1'b1; data = 1'b0; dis_n = 1'b1;
    #1;
    chk("R9 forced ones on alarm", tdata, 1'b1);
    chk("R11 valid follows high", tvalid, 1'b1);
    dis_n = 1'b0;
    #1;
    chk("R10 disabled passthrough", tdata, 1'b0);
    valid = 1'b0;
    #1;
    chk("R11 valid follows low", tvalid, 1'b0);
    @(negedge clk);
    dis_n = 1'b1; data = 1'b1;
  endtask

  task automatic t_clear;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    @(negedge clk);
    chk("R8 clear ignored during alarm", latched, 1'b1);
    send_window(20, 1'b0, 1'b0);
    chk("R4 one zero window keeps alarm", ais_n, 1'b0);
    send_window(20, 1'b0, 1'b0);
    chk("R4 cleared", ais_n, 1'b1);
    chk("R7 latched holds", latched, 1'b1);
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    @(negedge clk);
    chk("R8 clear accepted", latched, 1'b0);
  endtask

  task automatic t_framed;
    for (int w = 0; w < 4; w++) begin
      send_window(5, 1'b1, 1'b0);
      chk("R5 framed all-ones payload", ais_n, 1'b1);
    end
  endtask

  task automatic t_realign;
    send_bits(700, 7, 1'b0, 1'b0);
    send_window(0, 1'b1, 1'b0);
    chk("R6 first aligned window", ais_n, 1'b1);
    send_window(1, 1'b0, 1'b0);
    chk("R6 partial window discarded", ais_n, 1'b0);
    send_window(10, 1'b0, 1'b0);
    send_window(10, 1'b0, 1'b0);
    chk("R4 cleared again", ais_n, 1'b1);
  endtask

  task automatic t_lof;
    @(negedge clk);
    lof = 1'b1; valid = 1'b1; data = 1'b0; dis_n = 1'b1;
    #1;
    chk("R9 forced ones on lof", tdata, 1'b1);
    dis_n = 1'b0;
    #1;
    chk("R10 lof disabled passthrough", tdata, 1'b0);
    @(negedge clk);
    valid = 1'b0;
    chk("R10 lof raises no alarm", ais_n, 1'b1);
    lof = 1'b0; dis_n = 1'b1;
    #1;
    chk("R9 no forcing without cause", tdata, 1'b0);
    @(negedge clk); data = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_declare();
    t_insert();
    t_clear();
    t_framed();
    t_realign();
    t_lof();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule